// File: doc/BRIEF.md
# Windowed Trigger Pulse-Pair Sequencer

This block decides, once per beam cycle, when a pulse-pair of sequence starts is issued. A fiducial strobe marks the start of each beam cycle and restarts a tick counter. Two trigger strobes are then judged against that counter. The accelerate trigger must fall inside a wide window around its expected tick. The standby trigger must fall inside a narrow window whose centre is picked by a 3-bit window number. Every accepted trigger produces a one-cycle start strobe.

When the accelerate trigger is missing, out of time or not enabled, the standby trigger still starts a sequence. A backup start then follows it a fixed number of ticks later, so the pair is always complete. A standby trigger outside its window produces no start at all. It raises an error flag instead. Three per-cycle flags report what was seen since the last fiducial. Pulse shaping, delay programming and register access are handled elsewhere.

At the default settings one tick is one period of a 119 MHz clock. The accelerate window is ±1190 ticks around tick 121618. The standby windows are ±119 ticks. The backup delay is 5355 ticks. All of these are parameters.

Top module: `sbs_pair_seq`

## Requirements
- R1: While reset is applied, and afterwards until the first fiducial, start_o, acc_ok_o, stby_ok_o and stby_err_o are low. A trigger that arrives before any fiducial is never accepted. A standby trigger at that point raises stby_err_o.
- R2: A trigger's time is the number of rising clock edges between the edge that captured the fiducial and the edge that captures the trigger. The first cycle after the fiducial cycle is time 1. An accelerate trigger is accepted when its time t satisfies ACC_EXPECT-ACC_HALF <= t <= ACC_EXPECT+ACC_HALF and the synchronised enable is high. An accepted accelerate trigger sets acc_ok_o and makes start_o high for the one cycle after the edge that captures the trigger.
- R3: For a window number s from 1 to 5, the expected standby time is STBY_BASE + (s-1)*STBY_STEP. A standby trigger whose time lies within ±STBY_HALF of that value is accepted. It sets stby_ok_o and makes start_o high for the one cycle after the capturing edge.
- R4: When both triggers are accepted in the same beam cycle, exactly two start strobes are issued and no backup start is added.
- R5: When a standby trigger is accepted and no accelerate trigger has been accepted since the fiducial, a second start strobe follows the first by exactly BACKUP_DLY cycles.
- R6: acc_en_i passes through a two-stage synchroniser. While the synchronised enable is low, no accelerate trigger is accepted and acc_ok_o stays low, so the cycle takes the backup path of R5.
- R7: A standby trigger with a valid window number but a time outside its window sets stby_err_o. It produces neither a start nor a backup start.
- R8: Window numbers 0, 6 and 7 are invalid. Every standby trigger under an invalid window number sets stby_err_o and produces no start.
- R9: A fiducial clears acc_ok_o, stby_ok_o and stby_err_o on the edge that captures it. Triggers present in the fiducial cycle are ignored. A beam cycle with no trigger produces no start.
- R10: Only the first accepted accelerate trigger and the first accepted standby trigger of a beam cycle produce starts. Later in-window repeats of either are ignored and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fid_i | input | 1 | Fiducial strobe, starts a beam cycle |
| acc_trig_i | input | 1 | Accelerate trigger strobe |
| stby_trig_i | input | 1 | Standby trigger strobe |
| acc_en_i | input | 1 | Accelerate enable level, asynchronous |
| win_sel_i | input | 3 | Standby window number, 1 to 5 valid |
| start_o | output | 1 | One-cycle sequence start strobe |
| acc_ok_o | output | 1 | Accelerate accepted since last fiducial |
| stby_ok_o | output | 1 | Standby accepted since last fiducial |
| stby_err_o | output | 1 | Standby seen out of window since last fiducial |

## Verification
A corrupted tick counter misplaces every window. It shows up on the edge after the next trigger, as a flag set or left clear against expectation and a start strobe present or missing. A backup countdown that is stuck, or loaded when it should not be, shows as an extra, missing or shifted start exactly BACKUP_DLY cycles after the standby start. A per-cycle reference model compares start_o and all three flags on every clock, so any divergence is reported within one cycle of reaching the ports.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int unsigned WIN_FIRST   = 1;
    localparam int unsigned WIN_LAST    = 5;
    localparam int unsigned SYNC_STAGES = 2;

    function automatic logic win_sel_valid(input logic [2:0] sel);
        return (sel >= 3'(WIN_FIRST)) && (sel <= 3'(WIN_LAST));
    endfunction
endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i) begin
                if (!rst_ni) sh_q <= '0;
                else         sh_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk_i) begin
                if (!rst_ni) sh_q <= '0;
                else         sh_q <= {sh_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sbs_window.sv
module sbs_window #(
    parameter int unsigned W    = 18,
    parameter int unsigned HALF = 119
) (
    input  logic [W-1:0] t_i,
    input  logic [W-1:0] center_i,
    output logic         hit_o
);
    logic [W:0] t_x, c_x;

    always_comb begin
        t_x   = {1'b0, t_i};
        c_x   = {1'b0, center_i};
        hit_o = ((t_x + (W+1)'(HALF)) >= c_x) && (t_x <= (c_x + (W+1)'(HALF)));
    end
endmodule

// File: rtl/sbs_pair_seq.sv
module sbs_pair_seq #(
    parameter int unsigned CNT_W      = 18,
    parameter int unsigned ACC_EXPECT = 121618,
    parameter int unsigned ACC_HALF   = 1190,
    parameter int unsigned STBY_BASE  = 124800,
    parameter int unsigned STBY_STEP  = 1024,
    parameter int unsigned STBY_HALF  = 119,
    parameter int unsigned BACKUP_DLY = 5355
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       fid_i,
    input  logic       acc_trig_i,
    input  logic       stby_trig_i,
    input  logic       acc_en_i,
    input  logic [2:0] win_sel_i,
    output logic       start_o,
    output logic       acc_ok_o,
    output logic       stby_ok_o,
    output logic       stby_err_o
);
    import sbs_pkg::*;

    localparam int unsigned BK_W = $clog2(BACKUP_DLY + 1);

    typedef struct packed {
        logic [CNT_W-1:0] tcnt;
        logic             acc_ok;
        logic             stby_ok;
        logic             stby_err;
        logic             start;
        logic             bk_act;
        logic [BK_W-1:0]  bk_cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic             acc_en_s;
    logic             acc_hit, stby_hit, sel_ok;
    logic [2:0]       win_idx;
    logic [CNT_W-1:0] stby_ctr;

    sbs_sync #(.STAGES(SYNC_STAGES)) en_sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (acc_en_i),
        .q_o    (acc_en_s)
    );

    always_comb begin
        sel_ok   = win_sel_valid(win_sel_i);
        win_idx  = sel_ok ? (win_sel_i - 3'd1) : 3'd0;
        stby_ctr = CNT_W'(STBY_BASE) + CNT_W'(win_idx) * CNT_W'(STBY_STEP);
    end

    sbs_window #(.W(CNT_W), .HALF(ACC_HALF)) acc_win_i (
        .t_i      (st_q.tcnt),
        .center_i (CNT_W'(ACC_EXPECT)),
        .hit_o    (acc_hit)
    );

    sbs_window #(.W(CNT_W), .HALF(STBY_HALF)) stby_win_i (
        .t_i      (st_q.tcnt),
        .center_i (stby_ctr),
        .hit_o    (stby_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;

        if (st_q.tcnt != '1) st_d.tcnt = st_q.tcnt + CNT_W'(1);

        if (st_q.bk_act) begin
            if (st_q.bk_cnt == BK_W'(1)) begin
                st_d.start  = 1'b1;
                st_d.bk_act = 1'b0;
            end else begin
                st_d.bk_cnt = st_q.bk_cnt - BK_W'(1);
            end
        end

        if (fid_i) begin
            st_d.tcnt     = CNT_W'(1);
            st_d.acc_ok   = 1'b0;
            st_d.stby_ok  = 1'b0;
            st_d.stby_err = 1'b0;
        end else begin
            if (acc_trig_i && acc_hit && acc_en_s && !st_q.acc_ok && !st_q.stby_ok) begin
                st_d.acc_ok = 1'b1;
                st_d.start  = 1'b1;
            end
            if (stby_trig_i) begin
                if (sel_ok && stby_hit) begin
                    if (!st_q.stby_ok) begin
                        st_d.stby_ok = 1'b1;
                        st_d.start   = 1'b1;
                        if (!st_q.acc_ok) begin
                            st_d.bk_act = 1'b1;
                            st_d.bk_cnt = BK_W'(BACKUP_DLY);
                        end
                    end
                end else begin
                    st_d.stby_err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.tcnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o    = st_q.start;
    assign acc_ok_o   = st_q.acc_ok;
    assign stby_ok_o  = st_q.stby_ok;
    assign stby_err_o = st_q.stby_err;
endmodule

// File: rtl/sbs_pair_seq_chk.sv
module sbs_pair_seq_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       fid_i,
    input logic       stby_trig_i,
    input logic [2:0] win_sel_i,
    input logic       en_sync,
    input logic       start_o,
    input logic       acc_ok_o,
    input logic       stby_ok_o,
    input logic       stby_err_o
);
    assert_fid_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fid_i |=> (!acc_ok_o && !stby_ok_o && !stby_err_o));

    assert_acc_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(acc_ok_o) |-> start_o);

    assert_stby_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stby_ok_o) |-> start_o);

    assert_err_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stby_err_o) |-> !$rose(stby_ok_o));

    assert_en_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(acc_ok_o) |-> $past(en_sync));

    assert_bad_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stby_trig_i && !fid_i && (win_sel_i == 3'd0 || win_sel_i > 3'd5)) |=> stby_err_o);
endmodule

bind sbs_pair_seq sbs_pair_seq_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fid_i       (fid_i),
    .stby_trig_i (stby_trig_i),
    .win_sel_i   (win_sel_i),
    .en_sync     (acc_en_s),
    .start_o     (start_o),
    .acc_ok_o    (acc_ok_o),
    .stby_ok_o   (stby_ok_o),
    .stby_err_o  (stby_err_o)
);

// File: tb/sbs_pair_seq_tb.sv
module sbs_pair_seq_tb_top;
    localparam int AE = 200, AH = 20, SB = 400, SS = 64, SH = 4, BD = 90;
    localparam int LEN = 900;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fid = 1'b0, acc = 1'b0, stby = 1'b0, en = 1'b1;
    logic [2:0] sel = 3'd1;
    logic start_o, acc_ok_o, stby_ok_o, stby_err_o;

    int n_chk = 0, n_err = 0, n_start = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    sbs_pair_seq #(.CNT_W(12), .ACC_EXPECT(AE), .ACC_HALF(AH), .STBY_BASE(SB),
                   .STBY_STEP(SS), .STBY_HALF(SH), .BACKUP_DLY(BD)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .fid_i(fid), .acc_trig_i(acc), .stby_trig_i(stby),
        .acc_en_i(en), .win_sel_i(sel), .start_o(start_o), .acc_ok_o(acc_ok_o),
        .stby_ok_o(stby_ok_o), .stby_err_o(stby_err_o));

    // behavioural reference
    int  m_time, ecnt;
    bit  m_acc, m_stby, m_err, m_start, en1, en2;
    int  bq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_time = 1 << 30; ecnt = 0; m_acc = 0; m_stby = 0; m_err = 0;
            m_start = 0; en1 = 0; en2 = 0; bq.delete();
        end else begin
            bit oa, os;
            int base;
            ecnt++;
            m_start = 0;
            if (bq.size() > 0 && bq[0] == ecnt) begin m_start = 1; void'(bq.pop_front()); end
            oa = m_acc; os = m_stby;
            if (fid) begin
                m_time = 1; m_acc = 0; m_stby = 0; m_err = 0;
            end else begin
                if (acc && m_time >= AE - AH && m_time <= AE + AH && en2 && !oa && !os) begin
                    m_acc = 1; m_start = 1;
                end
                if (stby) begin
                    base = SB + (int'(sel) - 1) * SS;
                    if (sel >= 1 && sel <= 5 && m_time >= base - SH && m_time <= base + SH) begin
                        if (!os) begin
                            m_stby = 1; m_start = 1;
                            if (!oa) bq.push_back(ecnt + BD);
                        end
                    end else m_err = 1;
                end
                if (m_time < (1 << 30)) m_time++;
            end
            en2 = en1; en1 = en;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "start_o", start_o, m_start);
            chk(cur_req, "acc_ok_o", acc_ok_o, m_acc);
            chk(cur_req, "stby_ok_o", stby_ok_o, m_stby);
            chk(cur_req, "stby_err_o", stby_err_o, m_err);
            if (start_o) n_start++;
        end
    end

    // one beam cycle: fiducial, then triggers at the given times (0 = none)
    task automatic beam(input string req, input int a1, input int a2, input int s1, input int s2,
                        input int exp_starts, input int exp_a, input int exp_s, input int exp_e);
        cur_req = req;
        fid = 1'b1;
        @(negedge clk);
        fid = 1'b0;
        n_start = 0;
        for (int j = 1; j <= LEN; j++) begin
            acc  = (j == a1) || (j == a2);
            stby = (j == s1) || (j == s2);
            @(negedge clk);
        end
        acc = 1'b0; stby = 1'b0;
        chk(req, "start count", n_start, exp_starts);
        chk(req, "acc flag", acc_ok_o, exp_a);
        chk(req, "stby flag", stby_ok_o, exp_s);
        chk(req, "err flag", stby_err_o, exp_e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "start_o in reset", start_o, 0);
        chk("R1", "acc_ok_o in reset", acc_ok_o, 0);
        chk("R1", "stby_ok_o in reset", stby_ok_o, 0);
        chk("R1", "stby_err_o in reset", stby_err_o, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: triggers before any fiducial
        acc = 1'b1; stby = 1'b1;
        @(negedge clk);
        acc = 1'b0; stby = 1'b0;
        chk("R1", "no start before fiducial", start_o, 0);
        chk("R1", "err before fiducial", stby_err_o, 1);
        chk("R1", "acc before fiducial", acc_ok_o, 0);
        repeat (3) @(negedge clk);

        sel = 3'd1; beam("R4", AE, 0, SB, 0, 2, 1, 1, 0);
        sel = 3'd2; beam("R2", AE - AH, 0, SB + SS + SH, 0, 2, 1, 1, 0);
        sel = 3'd3; beam("R3", AE + AH, 0, SB + 2*SS - SH, 0, 2, 1, 1, 0);
        sel = 3'd4; beam("R5", AE + AH + 1, 0, SB + 3*SS, 0, 2, 0, 1, 0);
        sel = 3'd5; beam("R5", 0, 0, SB + 4*SS, 0, 2, 0, 1, 0);
        en = 1'b0; repeat (5) @(negedge clk);
        sel = 3'd1; beam("R6", AE, 0, SB, 0, 2, 0, 1, 0);
        en = 1'b1; repeat (5) @(negedge clk);
        beam("R7", AE, 0, SB + SH + 1, 0, 1, 1, 0, 1);
        beam("R7", 0, 0, SB - SH - 1, 0, 0, 0, 0, 1);
        sel = 3'd0; beam("R8", 0, 0, SB, 0, 0, 0, 0, 1);
        sel = 3'd6; beam("R8", AE, 0, SB, 0, 1, 1, 0, 1);
        sel = 3'd7; beam("R8", AE, 0, SB + 6*SS, 0, 1, 1, 0, 1);
        sel = 3'd1; beam("R9", 0, 0, 0, 0, 0, 0, 0, 0);
        beam("R10", AE - 5, AE + 5, SB - 2, SB + 2, 2, 1, 1, 0);
        beam("R10", 0, 0, SB - 1, SB + 1, 2, 0, 1, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule